// File: doc/BRIEF.md
# Phase-Correct PWM Timer Channel

This block is an 8-bit timer that counts up from 0 to 255 and back down to 0, never wrapping, and drives one center-aligned PWM output from a compare value. A count enable is taken from the system clock through a power-of-two divider with seven selectable ratios. One full triangle lasts 510 timer ticks, so the output frequency is the clock divided by 510 times the selected ratio. The output clears on a compare match while the counter rises and sets on a match while it falls. A polarity input can invert the output.

The compare value is double-buffered. A write goes into a holding register, and the counter loads it into the active comparator when it arrives at 255. At that point the output is also forced to the level a rising match would give, so the waveform stays symmetric around 0. This covers the case where a rising match was skipped because the compare value changed away from 255, or because the counter was preloaded past the compare value. The counter can be preloaded at any time. A one-clock pulse marks each arrival at 0.

Top module: `pcpwm_timer`

## Requirements
- R1: While reset is held and directly after it, the count is 0, the direction is up, the internal output level is low (so `pwm_out` is low with `invert`=0), `ovf_pulse` is low and the divider is cleared.
- R2: On every tick the count moves by exactly one step: 0 up to 255, then down to 0, then up again. It never wraps, so a full period is 510 ticks. With divide-by-1, the count after k enabled clocks from reset is k for k≤255, 254 after 256 clocks and 0 after 510 clocks.
- R3: `presc_sel` selects the divide ratio: 0→1, 1→8, 2→32, 3→64, 4→128, 5→256, 6→1024, and 7 stops the ticks. The divider counts enabled clocks from reset, and the first tick comes on the N-th enabled clock.
- R4: In non-inverted mode, a compare value c with 0<c<255 clears the output when the rising count reaches c and sets it when the falling count reaches c. The output is therefore high for 2·c of every 510 ticks.
- R5: A compare value of 0 keeps the output low at all times. A compare value of 255 keeps it high from the first arrival at 255 onward.
- R6: Whenever the counter arrives at 255 on a tick, the output takes the level of a rising match (low), unless the newly active compare value is 255. This covers the case where the compare value leaves 255.
- R7: If the counter is preloaded above the compare value while rising, the skipped clear is supplied on arrival at 255.
- R8: A pulse on `cmp_wr` captures `cmp_data` into a holding register. The active comparator takes that value only when the counter arrives at 255, so writes made mid-period do not change the current period.
- R9: With `invert`=1, `pwm_out` is the complement of the non-inverted waveform, so the high time becomes 510−2·c ticks.
- R10: `ovf_pulse` is high for exactly one clock each time a tick moves the count to 0.
- R11: With `enable` low, the count, the divider and the output level hold.
- R12: `load` writes `load_value` into the count on the next clock, whether or not the timer is enabled, and takes priority over a tick. It leaves the direction and the output level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the divider and the counter |
| presc_sel | input | 3 | Divide-ratio select (see R3) |
| cmp_wr | input | 1 | Captures cmp_data into the compare holding register |
| cmp_data | input | 8 | New compare value |
| invert | input | 1 | 1 = inverted output polarity |
| load | input | 1 | Preloads the counter |
| load_value | input | 8 | Value for the preload |
| pwm_out | output | 1 | PWM output |
| count_out | output | 8 | Current counter value |
| ovf_pulse | output | 1 | One-clock pulse when the count reaches 0 |

## Verification
The hardest situations to reach are the two forced transitions at 255: a rising match skipped by a preload, and a compare value leaving 255. Neither happens in steady running. The stimulus first lets a buffered compare value become active at 255, then waits on the observed count until the ramp is rising below the compare value, and preloads a value above it. For the other case it runs a full period with compare 255, writes a new value and follows the ramp to the next 255. The double buffer is shown by writing a new value mid-ramp and checking that the old match point still acts until the following 255.

// File: rtl/pcpwm_pkg.sv
// Package: shared constants and helpers for the phase-correct PWM timer.
// Assumes the divider taps are powers of two and listed in select order.
package pcpwm_pkg;

    // Number of selectable divider taps (select codes 0..6); code 7 stops ticks.
    localparam int NUM_TAPS = 7;

    // Returns log2 of the division ratio for a select code.
    function automatic int tap_shift(input int idx);
        case (idx)
            0:       return 0;
            1:       return 3;
            2:       return 5;
            3:       return 6;
            4:       return 7;
            5:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
// Module: clock divider producing a one-clock count-enable pulse.
// Counts enabled clocks from reset; a tap fires when its low bits are all ones.
// Assumes DIV_W is at least the widest tap shift (10).
module pcpwm_prescaler #(
    parameter int DIV_W = 10,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    import pcpwm_pkg::*;

    localparam int NUM_SEL = 1 << SEL_W;

    logic [DIV_W-1:0]   div_q;
    logic [NUM_SEL-1:0] tap_hit;

    // Free-running divider count, advanced only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (enable) begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // One tap per select code; codes past the tap list never fire.
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_tap
        if (i < NUM_TAPS) begin : g_live
            localparam int SH = tap_shift(i);
            localparam logic [DIV_W-1:0] MASK = DIV_W'((64'd1 << SH) - 64'd1);
            assign tap_hit[i] = ((div_q & MASK) == MASK);
        end else begin : g_off
            assign tap_hit[i] = 1'b0;
        end
    end

    // Count enable for the selected ratio.
    always_comb begin
        tick = enable && tap_hit[sel];
    end

endmodule

// File: rtl/pcpwm_updown.sv
// Module: up/down counter between 0 and the all-ones maximum.
// Reverses at both ends, never wraps; a preload wins over a tick and keeps
// the direction. Flags a one-clock pulse whenever a tick lands on 0.
module pcpwm_updown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_value,
    output logic [W-1:0] count,
    output logic [W-1:0] nxt,
    output logic         step_up,
    output logic         dir_up,
    output logic         ovf
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic         dir_q;
    logic         ovf_q;

    // Direction of the coming step and the value it leads to.
    always_comb begin
        step_up = dir_q ? (cnt_q != MAXV) : (cnt_q == '0);
        nxt     = step_up ? cnt_q + W'(1) : cnt_q - W'(1);
    end

    // Count, direction and bottom-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b1;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (load) begin
                cnt_q <= load_value;
            end else if (tick) begin
                cnt_q <= nxt;
                ovf_q <= (nxt == '0);
                if (nxt == MAXV) begin
                    dir_q <= 1'b0;
                end else if (nxt == '0) begin
                    dir_q <= 1'b1;
                end else begin
                    dir_q <= step_up;
                end
            end
        end
    end

    assign count  = cnt_q;
    assign dir_up = dir_q;
    assign ovf    = ovf_q;

endmodule

// File: rtl/pcpwm_compare.sv
// Module: double-buffered compare and output-level logic.
// The held value becomes active on arrival at maximum; at that point the level
// is forced to the rising-match result unless the active value is maximum.
// Falling matches at value 0 do not set, so a compare of 0 stays low.
module pcpwm_compare #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] nxt,
    input  logic         step_up,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_data,
    output logic [W-1:0] cmp_act,
    output logic         lvl
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] hold_q;
    logic [W-1:0] act_q;
    logic         lvl_q;
    logic         moving;

    // A counter step happens this cycle.
    always_comb begin
        moving = tick && !load;
    end

    // Holding register for writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (cmp_wr) begin
            hold_q <= cmp_data;
        end
    end

    // Active compare value, refreshed on arrival at maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (moving && nxt == MAXV) begin
            act_q <= hold_q;
        end
    end

    // Output level: forced at maximum, otherwise changed by matches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else if (moving) begin
            if (nxt == MAXV) begin
                lvl_q <= (hold_q == MAXV);
            end else if (nxt == act_q) begin
                if (step_up) begin
                    lvl_q <= 1'b0;
                end else if (act_q != '0) begin
                    lvl_q <= 1'b1;
                end
            end
        end
    end

    assign cmp_act = act_q;
    assign lvl     = lvl_q;

endmodule

// File: rtl/pcpwm_timer.sv
// Module: top of the phase-correct PWM timer channel.
// Ties divider, triangle counter and compare unit together; polarity is
// applied at the pin. Assumes invert is a static configuration input.
module pcpwm_timer #(
    parameter int CNT_W = 8,
    parameter int DIV_W = 10,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_data,
    input  logic             invert,
    input  logic             load,
    input  logic [CNT_W-1:0] load_value,
    output logic             pwm_out,
    output logic [CNT_W-1:0] count_out,
    output logic             ovf_pulse
);
    logic             tick;
    logic [CNT_W-1:0] nxt;
    logic             step_up;
    logic             dir_up;
    logic [CNT_W-1:0] cmp_act;
    logic             lvl;

    pcpwm_prescaler #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .sel    (presc_sel),
        .tick   (tick)
    );

    pcpwm_updown #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (load),
        .load_value (load_value),
        .count      (count_out),
        .nxt        (nxt),
        .step_up    (step_up),
        .dir_up     (dir_up),
        .ovf        (ovf_pulse)
    );

    pcpwm_compare #(.W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (load),
        .nxt      (nxt),
        .step_up  (step_up),
        .cmp_wr   (cmp_wr),
        .cmp_data (cmp_data),
        .cmp_act  (cmp_act),
        .lvl      (lvl)
    );

    // Pin polarity.
    always_comb begin
        pwm_out = lvl ^ invert;
    end

endmodule

// File: rtl/pcpwm_timer_chk.sv
// Module: property checker bound to the timer top.
// Observes the count enable, direction, level and active compare value.
module pcpwm_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic         load,
    input logic         tick,
    input logic [W-1:0] count_out,
    input logic         dir_up,
    input logic         lvl,
    input logic [W-1:0] cmp_act,
    input logic         ovf_pulse
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // R2: each tick moves the count by exactly one.
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> ((count_out == $past(count_out) + W'(1)) ||
                             (count_out == $past(count_out) - W'(1))));

    // R5/R6: arrival at maximum forces the rising-match level unless compare is maximum.
    assert_max_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && dir_up && count_out == MAXV - W'(1))
            |=> (lvl == (cmp_act == MAXV)));

    // R10: the pulse appears only at 0 and lasts one clock.
    assert_ovf_bottom_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count_out == '0));

    assert_ovf_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);

    // R11: a disabled timer holds its count.
    assert_hold_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !load) |=> $stable(count_out));

    // R11/R12: the level changes only on a tick, never through a preload.
    assert_level_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick || load) |=> $stable(lvl));

endmodule

bind pcpwm_timer pcpwm_timer_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .load      (load),
    .tick      (tick),
    .count_out (count_out),
    .dir_up    (dir_up),
    .lvl       (lvl),
    .cmp_act   (cmp_act),
    .ovf_pulse (ovf_pulse)
);

// File: tb/pcpwm_timer_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, sampling and driving on the falling edge.
module pcpwm_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [2:0] presc_sel = 3'd0;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_data = 8'd0;
    logic       invert = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_value = 8'd0;
    logic       pwm_out;
    logic [7:0] count_out;
    logic       ovf_pulse;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    pcpwm_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .presc_sel  (presc_sel),
        .cmp_wr     (cmp_wr),
        .cmp_data   (cmp_data),
        .invert     (invert),
        .load       (load),
        .load_value (load_value),
        .pwm_out    (pwm_out),
        .count_out  (count_out),
        .ovf_pulse  (ovf_pulse)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; enable = 1'b0; presc_sel = 3'd0; cmp_wr = 1'b0;
        cmp_data = 8'd0; invert = 1'b0; load = 1'b0; load_value = 8'd0;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic start(input logic [2:0] sel);
        presc_sel = sel;
        enable = 1'b1;
    endtask

    task automatic write_cmp(input logic [7:0] v);
        cmp_data = v; cmp_wr = 1'b1;
        step(1);
        cmp_wr = 1'b0;
    endtask

    task automatic wait_count(input logic [7:0] v, input string req);
        int n = 0;
        do begin
            step(1);
            n++;
        end while (count_out != v && n < 3000);
        check(req, "count reached", int'(count_out), int'(v));
    endtask

    task automatic measure_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) hi++;
            step(1);
        end
    endtask

    // R1: reset values.
    task automatic t_reset();
        do_reset();
        check("R1", "count after reset", int'(count_out), 0);
        check("R1", "pwm after reset", int'(pwm_out), 0);
        check("R1", "ovf after reset", int'(ovf_pulse), 0);
    endtask

    // R2/R10: ramp shape and bottom pulse.
    task automatic t_ramp();
        int pulses = 0;
        do_reset(); start(3'd0);
        step(100);  check("R2", "count after 100", int'(count_out), 100);
        step(155);  check("R2", "count at top", int'(count_out), 255);
        step(1);    check("R2", "count after top", int'(count_out), 254);
        step(254);  check("R2", "count at bottom", int'(count_out), 0);
        check("R10", "pulse at bottom", int'(ovf_pulse), 1);
        step(1);    check("R2", "count after bottom", int'(count_out), 1);
        check("R10", "pulse one clock", int'(ovf_pulse), 0);
        for (int i = 0; i < 1020; i++) begin
            step(1);
            if (ovf_pulse) pulses++;
        end
        check("R10", "pulses in two periods", pulses, 2);
    endtask

    // R3: divide ratios and the stop code.
    task automatic t_presc();
        do_reset(); start(3'd1);
        step(80); check("R3", "div8 after 80", int'(count_out), 10);
        step(7);  check("R3", "div8 after 87", int'(count_out), 10);
        step(1);  check("R3", "div8 after 88", int'(count_out), 11);
        do_reset(); start(3'd6);
        step(1023); check("R3", "div1024 before first", int'(count_out), 0);
        step(1025); check("R3", "div1024 after 2048", int'(count_out), 2);
        do_reset(); start(3'd7);
        step(100); check("R3", "stop code", int'(count_out), 0);
    endtask

    // R4/R5/R9: high time over one period.
    task automatic t_duty(input logic [7:0] c, input logic inv, input int exp, input string req);
        int hi;
        do_reset(); invert = inv; start(3'd0);
        write_cmp(c);
        wait_count(8'd255, req);
        measure_high(510, hi);
        check(req, $sformatf("high ticks c=%0d inv=%0d", c, inv), hi, exp);
    endtask

    // R8: a mid-ramp write waits for the next top.
    task automatic t_buffer();
        do_reset(); start(3'd0);
        write_cmp(8'd100);
        wait_count(8'd255, "R8");
        wait_count(8'd0, "R8");
        wait_count(8'd50, "R8");
        check("R8", "high below old compare", int'(pwm_out), 1);
        write_cmp(8'd30);
        wait_count(8'd150, "R8");
        check("R8", "old compare still clears", int'(pwm_out), 0);
        wait_count(8'd40, "R8");
        check("R8", "no set above new compare", int'(pwm_out), 0);
        wait_count(8'd29, "R8");
        check("R8", "new compare sets", int'(pwm_out), 1);
    endtask

    // R7: preload past the compare value while rising.
    task automatic t_preload_above();
        do_reset(); start(3'd0);
        write_cmp(8'd100);
        wait_count(8'd255, "R7");
        wait_count(8'd0, "R7");
        wait_count(8'd20, "R7");
        load_value = 8'd150; load = 1'b1;
        step(1);
        load = 1'b0;
        check("R12", "preloaded count", int'(count_out), 150);
        check("R12", "level kept on preload", int'(pwm_out), 1);
        wait_count(8'd200, "R7");
        check("R7", "clear skipped", int'(pwm_out), 1);
        wait_count(8'd255, "R7");
        check("R7", "forced clear at top", int'(pwm_out), 0);
        step(1);
        check("R7", "low after top", int'(pwm_out), 0);
    endtask

    // R5/R6: compare leaving the maximum.
    task automatic t_leave_max();
        int hi;
        do_reset(); start(3'd0);
        write_cmp(8'd255);
        wait_count(8'd255, "R5");
        check("R5", "high at top", int'(pwm_out), 1);
        measure_high(510, hi);
        check("R5", "constant high", hi, 510);
        write_cmp(8'd100);
        wait_count(8'd255, "R6");
        check("R6", "forced low at top", int'(pwm_out), 0);
        step(1);
        check("R6", "low after top", int'(pwm_out), 0);
        wait_count(8'd99, "R6");
        check("R6", "set on fall", int'(pwm_out), 1);
    endtask

    // R11/R12: hold while disabled and preload while disabled.
    task automatic t_hold();
        do_reset(); start(3'd0);
        write_cmp(8'd100);
        wait_count(8'd255, "R11");
        wait_count(8'd50, "R11");
        enable = 1'b0;
        step(30);
        check("R11", "count held", int'(count_out), 50);
        check("R11", "level held", int'(pwm_out), 1);
        load_value = 8'd77; load = 1'b1;
        step(1);
        load = 1'b0;
        check("R12", "preload while disabled", int'(count_out), 77);
        check("R12", "level after preload", int'(pwm_out), 1);
        enable = 1'b1;
        step(1);
        check("R12", "direction kept", int'(count_out), 76);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_ramp();
        t_presc();
        t_duty(8'd100, 1'b0, 200, "R4");
        t_duty(8'd1,   1'b0, 2,   "R4");
        t_duty(8'd0,   1'b0, 0,   "R5");
        t_duty(8'd255, 1'b0, 510, "R5");
        t_duty(8'd100, 1'b1, 310, "R9");
        t_duty(8'd0,   1'b1, 510, "R9");
        t_buffer();
        t_preload_above();
        t_leave_max();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule